// File: doc/BRIEF.md
# Dual-Sum Multiplexed Seven-Segment Driver

This block lights a four-digit seven-segment display that shares one set of segment lines across all digits. It takes two 4-bit binary sums: the current roll and the roll kept from the previous turn. It shows each of them as a two-digit decimal number. Only one digit is lit at a time. A prescaler sets how long each digit stays lit. A small sequencer then walks the four digit positions in a fixed rotation. While a digit is lit, the segment lines carry the decoded pattern for that digit's decimal value.

Each sum is split into a tens digit and a units digit by comparing it with ten. The selected digit goes through a combinational nibble-to-segment decoder. A zero in a tens position is blanked. With the default dwell of 50,000 cycles (about 1 ms at 50 MHz), a full sweep of four digits takes about 4 ms. The whole display then looks steadily lit. A single parameter sets whether segment and digit lines are driven active-low or active-high.

Top module: `dual_sum_display`

## Requirements
- R1: At most one bit of `digit_en` is in its "on" state at any time. From the first digit activation after reset onward, exactly one bit is on.
- R2: Bit i of `digit_en` enables display slot i. The slots light in this order: slot 0 = current-sum tens, slot 1 = current-sum units, slot 2 = previous-sum tens, slot 3 = previous-sum units. After slot 3 the order wraps back to slot 0.
- R3: Once lit, each slot stays lit for exactly `DWELL_CYCLES` clock cycles before the next slot takes over.
- R4: A sum v (0 to 15) is shown with tens digit 1 and units digit v-10 when v >= 10. Otherwise it is shown with tens digit 0 and units digit v.
- R5: Segment bit 0 is segment a and bit 6 is segment g. In logical (1 = lit) form, the digits 0 to 9 map to hex 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F. The pattern follows the sum inputs in the same cycle.
- R6: When a tens slot is lit and its tens digit is 0, every segment is off.
- R7: Reset is synchronous and active-low. While reset is held, every digit is off. After release, slot 0 lights on the `DWELL_CYCLES`-th rising edge.
- R8: With `ACTIVE_LOW` = 1, an on segment or digit is driven 0 and an off one is driven 1. With `ACTIVE_LOW` = 0, the levels are swapped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| present_sum | input | 4 | Binary sum of the current roll |
| previous_sum | input | 4 | Binary sum of the previous roll |
| seg_out | output | 7 | Segment lines a (bit 0) to g (bit 6), polarity per `ACTIVE_LOW` |
| digit_en | output | 4 | Digit enables, bit i = slot i, polarity per `ACTIVE_LOW` |

## Verification
The assertions assume that both sum inputs are stable across each rising edge. They also assume that reset is sampled like any other synchronous input. The blanking and dwell properties rely only on the sums and the enables at the ports. The bench changes the sums and reset a short time after a rising edge and samples on the falling edge. It sweeps all 256 pairs of 4-bit sums, including the values 13 to 15 that a dice total never reaches. It also applies a reset in the middle of a scan, with a second instance checked against the opposite polarity.

// File: rtl/dsd_pkg.sv
// Package: shared constants and types for the dual-sum display driver.
// Assumes a four-slot display and 4-bit binary sums.
package dsd_pkg;

    localparam int unsigned NUM_SLOTS = 4;
    localparam int unsigned SUM_W     = 4;
    localparam int unsigned SEG_W     = 7;

    // Display slot positions; the encoding is also the scan order.
    typedef enum logic [1:0] {
        SLOT_CUR_TENS  = 2'd0,
        SLOT_CUR_UNITS = 2'd1,
        SLOT_OLD_TENS  = 2'd2,
        SLOT_OLD_UNITS = 2'd3
    } slot_e;

    // Sequencer states: dark after reset, then one state per slot.
    typedef enum logic [2:0] {
        SCAN_DARK = 3'd0,
        SCAN_S0   = 3'd1,
        SCAN_S1   = 3'd2,
        SCAN_S2   = 3'd3,
        SCAN_S3   = 3'd4
    } scan_state_e;

    // Decimal split of one sum.
    typedef struct packed {
        logic [SUM_W-1:0] tens;
        logic [SUM_W-1:0] units;
    } dec_pair_t;

endpackage

// File: rtl/scan_prescaler.sv
// Module: scan_prescaler
// Emits a one-cycle tick every DWELL_CYCLES clocks; the tick marks the end
// of one digit's dwell. Assumes DWELL_CYCLES >= 1. Counter restarts at reset.
module scan_prescaler #(
    parameter int unsigned DWELL_CYCLES = 50000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    localparam int unsigned CNT_W = (DWELL_CYCLES > 1) ? $clog2(DWELL_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DWELL_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    assign tick = (cnt == LAST);

    // Purpose: free-running modulo-DWELL_CYCLES count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/digit_scanner.sv
// Module: digit_scanner
// Sequencer that stays dark after reset until the first tick, then lights
// slot 0 and advances one slot per tick, wrapping after slot 3.
// Assumes tick is a single-cycle pulse from the prescaler.
module digit_scanner
    import dsd_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick,
    output slot_e slot,
    output logic  lit
);

    scan_state_e state, state_nx;

    // Purpose: next-state rotation on each tick.
    always_comb begin
        state_nx = state;
        if (tick) begin
            unique case (state)
                SCAN_DARK: state_nx = SCAN_S0;
                SCAN_S0:   state_nx = SCAN_S1;
                SCAN_S1:   state_nx = SCAN_S2;
                SCAN_S2:   state_nx = SCAN_S3;
                SCAN_S3:   state_nx = SCAN_S0;
                default:   state_nx = SCAN_DARK;
            endcase
        end
    end

    // Purpose: state register with synchronous reset to dark.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SCAN_DARK;
        end else begin
            state <= state_nx;
        end
    end

    // Purpose: decode state into slot index and lit flag.
    always_comb begin
        lit  = 1'b1;
        slot = SLOT_CUR_TENS;
        unique case (state)
            SCAN_S0: slot = SLOT_CUR_TENS;
            SCAN_S1: slot = SLOT_CUR_UNITS;
            SCAN_S2: slot = SLOT_OLD_TENS;
            SCAN_S3: slot = SLOT_OLD_UNITS;
            default: lit  = 1'b0;
        endcase
    end

endmodule

// File: rtl/dec_split.sv
// Module: dec_split
// Splits a 4-bit binary value into a tens digit (0 or 1) and units digit.
// Assumes the value is at most 15, so a single subtraction of ten suffices.
module dec_split
    import dsd_pkg::*;
(
    input  logic [SUM_W-1:0] value,
    output dec_pair_t        digits
);

    localparam logic [SUM_W-1:0] TEN = SUM_W'(10);

    // Purpose: compare with ten and subtract once.
    always_comb begin
        if (value >= TEN) begin
            digits.tens  = SUM_W'(1);
            digits.units = value - TEN;
        end else begin
            digits.tens  = '0;
            digits.units = value;
        end
    end

endmodule

// File: rtl/seg_decoder.sv
// Module: seg_decoder
// Maps a nibble to a logical seven-segment pattern (1 = lit, bit 0 = a,
// bit 6 = g). A blank request forces all segments off. Assumes nothing
// about the nibble range; A..F get the usual letter shapes.
module seg_decoder
    import dsd_pkg::*;
(
    input  logic [3:0]       nibble,
    input  logic             blank,
    output logic [SEG_W-1:0] seg
);

    // Purpose: nibble-to-segment table with blanking override.
    always_comb begin
        unique case (nibble)
            4'h0: seg = 7'h3F;
            4'h1: seg = 7'h06;
            4'h2: seg = 7'h5B;
            4'h3: seg = 7'h4F;
            4'h4: seg = 7'h66;
            4'h5: seg = 7'h6D;
            4'h6: seg = 7'h7D;
            4'h7: seg = 7'h07;
            4'h8: seg = 7'h7F;
            4'h9: seg = 7'h6F;
            4'hA: seg = 7'h77;
            4'hB: seg = 7'h7C;
            4'hC: seg = 7'h39;
            4'hD: seg = 7'h5E;
            4'hE: seg = 7'h79;
            default: seg = 7'h71;
        endcase
        if (blank) begin
            seg = '0;
        end
    end

endmodule

// File: rtl/dual_sum_display.sv
// Module: dual_sum_display (top)
// Time-shares two 4-bit sums over a four-digit multiplexed seven-segment
// display. Each sum takes two slots (tens, units). A prescaler sets the
// per-slot dwell and a sequencer rotates the lit slot. Outputs are decoded
// from registered state and the live sums. Assumes sums are synchronous to clk.
module dual_sum_display
    import dsd_pkg::*;
#(
    parameter int unsigned DWELL_CYCLES = 50000,
    parameter bit          ACTIVE_LOW   = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SUM_W-1:0] present_sum,
    input  logic [SUM_W-1:0] previous_sum,
    output logic [SEG_W-1:0] seg_out,
    output logic [NUM_SLOTS-1:0] digit_en
);

    localparam int unsigned NUM_SUMS = NUM_SLOTS / 2;

    logic             tick;
    slot_e            slot;
    logic             lit;
    logic [SUM_W-1:0] sums  [NUM_SUMS];
    dec_pair_t        pairs [NUM_SUMS];
    logic             src;
    logic             is_tens;
    logic [3:0]       nibble;
    logic             blank;
    logic [SEG_W-1:0] seg_log;
    logic [NUM_SLOTS-1:0] en_log;

    assign sums[0] = present_sum;
    assign sums[1] = previous_sum;

    scan_prescaler #(
        .DWELL_CYCLES (DWELL_CYCLES)
    ) u_prescaler (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    digit_scanner u_scanner (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .slot  (slot),
        .lit   (lit)
    );

    for (genvar g = 0; g < NUM_SUMS; g++) begin : g_split
        dec_split u_split (
            .value  (sums[g]),
            .digits (pairs[g])
        );
    end

    // Purpose: pick the digit for the lit slot and decide blanking.
    always_comb begin
        src     = slot[1];
        is_tens = ~slot[0];
        nibble  = is_tens ? pairs[src].tens : pairs[src].units;
        blank   = !lit || (is_tens && (pairs[src].tens == '0));
    end

    seg_decoder u_decoder (
        .nibble (nibble),
        .blank  (blank),
        .seg    (seg_log)
    );

    // Purpose: one-hot logical digit enable for the lit slot.
    always_comb begin
        en_log = '0;
        if (lit) begin
            en_log[slot] = 1'b1;
        end
    end

    if (ACTIVE_LOW) begin : g_drive_low
        assign seg_out  = ~seg_log;
        assign digit_en = ~en_log;
    end else begin : g_drive_high
        assign seg_out  = seg_log;
        assign digit_en = en_log;
    end

endmodule

// Checker: port-level properties of dual_sum_display.
module dual_sum_display_chk #(
    parameter int unsigned DWELL_CYCLES = 50000,
    parameter bit          ACTIVE_LOW   = 1'b1
) (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] present_sum,
    input logic [3:0] previous_sum,
    input logic [6:0] seg_out,
    input logic [3:0] digit_en
);

    localparam int unsigned CW = $clog2(DWELL_CYCLES + 2) + 1;
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    logic [3:0]    en_log;
    logic [6:0]    seg_log;
    logic [3:0]    en_q;
    logic [CW-1:0] held;
    logic          changed;

    assign en_log  = ACTIVE_LOW ? ~digit_en : digit_en;
    assign seg_log = ACTIVE_LOW ? ~seg_out  : seg_out;
    assign changed = (en_log != en_q);

    // Purpose: count how long the current enable pattern has been held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
            held <= '0;
        end else begin
            en_q <= en_log;
            if (changed) begin
                held <= CW'(1);
            end else if (held != CMAX) begin
                held <= held + 1'b1;
            end
        end
    end

    // R1: never more than one digit on
    a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(en_log));

    // R2: a change between lit digits is a rotation by one slot
    a_r2_order: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q != 4'b0 && en_log != 4'b0 && changed)
        |-> (en_log == {en_q[2:0], en_q[3]}));

    // R3: dwell length between slot changes
    a_r3_dwell: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q != 4'b0 && en_log != 4'b0 && changed)
        |-> (held == CW'(DWELL_CYCLES)));

    // R5: a lit units slot always shows some segment
    a_r5_units_lit: assert property (@(posedge clk) disable iff (!rst_n)
        (en_log[1] || en_log[3]) |-> (seg_log != 7'h00));

    // R6: tens slot of a sum below ten is blank
    a_r6_blank: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_log[0] && present_sum < 4'd10) || (en_log[2] && previous_sum < 4'd10))
        |-> (seg_log == 7'h00));

    // R7: a reset cycle leaves every digit off
    a_r7_reset_dark: assert property (@(posedge clk)
        !rst_n |=> (en_log == 4'b0));

endmodule

bind dual_sum_display dual_sum_display_chk #(
    .DWELL_CYCLES (DWELL_CYCLES),
    .ACTIVE_LOW   (ACTIVE_LOW)
) u_chk (.*);

// File: tb/test_dual_sum_display.sv
// Bench: exhaustive sweep of both sums with a short dwell, two polarities.
module test_dual_sum_display;

    localparam int CLK_PERIOD = 10;
    localparam int DWELL      = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] present_sum = '0;
    logic [3:0] previous_sum = '0;
    logic [6:0] seg_lo, seg_hi;
    logic [3:0] en_lo, en_hi;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_sum_display #(.DWELL_CYCLES(DWELL), .ACTIVE_LOW(1'b1)) i_dual_sum_display (
        .clk(clk), .rst_n(rst_n), .present_sum(present_sum),
        .previous_sum(previous_sum), .seg_out(seg_lo), .digit_en(en_lo));

    dual_sum_display #(.DWELL_CYCLES(DWELL), .ACTIVE_LOW(1'b0)) i_dual_sum_display_hi (
        .clk(clk), .rst_n(rst_n), .present_sum(present_sum),
        .previous_sum(previous_sum), .seg_out(seg_hi), .digit_en(en_hi));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [6:0] digit_shape(input int d);
        case (d)
            0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
            4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
            8: return 7'h7F; default: return 7'h6F;
        endcase
    endfunction

    // R4/R5/R6: expected logical pattern for a slot
    function automatic logic [6:0] expect_seg(input int slot, input int cur, input int old);
        int v, tens, units;
        v     = (slot < 2) ? cur : old;
        tens  = (v >= 10) ? 1 : 0;
        units = v - 10 * tens;
        if (slot % 2 == 0) return (tens == 0) ? 7'h00 : digit_shape(tens);
        return digit_shape(units);
    endfunction

    logic rst_q = 1'b0;
    always @(posedge clk) rst_q <= rst_n;

    int prev_slot = -1;
    int dwell = 0;
    int dark = 0;
    bit seen = 1'b0;

    // Monitor: checks outputs each falling edge
    always @(negedge clk) begin
        logic [3:0] el;
        logic [6:0] sl;
        int slot;
        el = ~en_lo;
        sl = ~seg_lo;
        // R8: opposite-polarity instance drives complementary levels
        check(seg_hi == ~seg_lo, "R8 seg", seg_hi, ~seg_lo);
        check(en_hi == ~en_lo, "R8 en", en_hi, ~en_lo);
        if (!rst_q) begin
            check(el == 4'b0, "R7 dark in reset", el, 0);
            prev_slot = -1; dwell = 0; dark = 0; seen = 1'b0;
        end else if (el == 4'b0) begin
            if (seen) check(1'b0, "R1 dark after start", el, 1);
            dark++;
        end else begin
            check($countones(el) == 1, "R1 one digit", el, 1);
            slot = 0;
            for (int i = 0; i < 4; i++) if (el[i]) slot = i;
            check(sl == expect_seg(slot, present_sum, previous_sum), "R5 R6 pattern",
                  sl, expect_seg(slot, present_sum, previous_sum));
            if (!seen) begin
                check(slot == 0, "R7 first slot", slot, 0);
                check(dark == DWELL - 1, "R7 first delay", dark, DWELL - 1);
                dwell = 1;
            end else if (slot != prev_slot) begin
                check(slot == (prev_slot + 1) % 4, "R2 order", slot, (prev_slot + 1) % 4);
                check(dwell == DWELL, "R3 dwell", dwell, DWELL);
                dwell = 1;
            end else begin
                dwell++;
            end
            prev_slot = slot;
            seen = 1'b1;
        end
    end

    bit done = 1'b0;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R4 R5 R6: every pair of sums for one full sweep each
        for (int p = 0; p < 16; p++) begin
            for (int q = 0; q < 16; q++) begin
                @(posedge clk); #1;
                present_sum = 4'(p);
                previous_sum = 4'(q);
                repeat (4 * DWELL - 1) @(posedge clk);
            end
        end
        // R7: reset in the middle of a dwell
        repeat (DWELL + 1) @(posedge clk);
        #1 rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        present_sum = 4'd12;
        previous_sum = 4'd7;
        repeat (10 * DWELL) @(posedge clk);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule